// File: doc/BRIEF.md
# Tagged Dual Stack Unit

This block holds both stacks of a small 8/16-bit stack processor: a working stack for operands and a return stack for addresses. Each cycle it may accept one command. The command carries the three modifier bits of the current opcode, an operand pop count, a result push count and up to six result bytes. The block scales the counts for short (byte-pair) mode and cancels the pops in keep mode. It then shifts the selected stack in a single cycle. The ALU, fetch and memory all sit outside. The block only moves bytes.

Every stored byte carries a ninth bit that marks a process boundary. A break command on a stack removes entries one per cycle until a marked entry is on top. The marked entry itself is left in place. Both fill levels appear as counters, and they can also be read as bytes through a small I/O read port. An illegal command sets a sticky error flag and leaves both stacks as they were. Underflow is a pop that wants more bytes than the stack holds. Overflow is a command that would push the stack past its capacity.

Top module: `dsu`

## Requirements
- R1: After a synchronous reset, both depths are 0, both top outputs are 0, `err` is 0 and `busy` is 0.
- R2: `cmd_mode[1]` (opcode bit 6) set selects the return stack, clear selects the working stack; the stack that is not selected is left unchanged. Push byte k is taken from `cmd_data[8k+7:8k]`, and byte 0 becomes the new top.
- R3: `cmd_mode[0]` (opcode bit 5, short mode) doubles both item counts, so each item moves two bytes.
- R4: `cmd_mode[2]` (opcode bit 7, keep) removes nothing from the stack but still applies the pushes.
- R5: A command whose unscaled-by-keep pop byte count exceeds the depth sets `err` and leaves the stack unchanged.
- R6: A command whose resulting depth would exceed `DEPTH` (default 256) sets `err` and leaves the stack unchanged.
- R7: `err` stays set until reset, and commands that follow it still execute normally.
- R8: With `cmd_tag` set, only the deepest byte pushed by that command carries the boundary mark.
- R9: A break command on a stack that holds a marked byte raises `busy`. The block then pops one byte per cycle until the top byte is marked, and the marked byte remains on top. While `busy` is high, every command is ignored.
- R10: A break command on a stack with no marked byte changes nothing and does not raise `busy`.
- R11: `io_rdata` returns the low 8 bits of the working depth for `io_addr` 0x02 and of the return depth for 0x03. Any other address returns 0.
- R12: `wst_top`/`ret_top` present the top six bytes, with byte k at bits 8k+7:8k. Positions below the bottom of the stack read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_mode | input | 3 | Opcode bits 7..5: {keep, return-select, short} |
| cmd_pop | input | 2 | Items consumed (0..3) |
| cmd_push | input | 2 | Items produced (0..3) |
| cmd_brk | input | 1 | Break: unwind selected stack to nearest mark |
| cmd_tag | input | 1 | Mark the deepest byte pushed by this command |
| cmd_data | input | 48 | Push bytes, byte 0 becomes top |
| io_addr | input | 8 | I/O read address |
| io_rdata | output | 8 | I/O read data (depth counters) |
| wst_top | output | 48 | Top six bytes of the working stack |
| ret_top | output | 48 | Top six bytes of the return stack |
| wst_depth | output | 9 | Working stack fill in bytes |
| ret_depth | output | 9 | Return stack fill in bytes |
| busy | output | 1 | An unwind is in progress |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions assume that `cmd_mode`, `cmd_brk` and `cmd_valid` are known in every cycle after reset. They also assume that a command offered while `busy` is high is meant to be dropped and not held back. The stimulus changes inputs only on the falling edge and lowers `cmd_valid` after each command. It deliberately keeps a push asserted throughout an unwind, so that the dropping is observed at the ports. Overflow is reached by filling the working stack to exactly its capacity with legal commands.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

    localparam int MAX_BYTES = 6;
    localparam int CNT_W     = 3;

    // positions inside cmd_mode
    localparam int MODE_KEEP  = 2;
    localparam int MODE_RET   = 1;
    localparam int MODE_SHORT = 0;

    typedef struct packed {
        logic       tag;
        logic [7:0] val;
    } dsu_ent_t;

    typedef struct packed {
        logic             sel_ret;
        logic [CNT_W-1:0] pop_b;   // bytes actually removed
        logic [CNT_W-1:0] need_b;  // bytes that must be present
        logic [CNT_W-1:0] push_b;  // bytes written
    } dsu_ctl_t;

    function automatic logic [CNT_W-1:0] item_bytes(input logic [1:0] items,
                                                    input logic       is_short);
        return is_short ? {items, 1'b0} : {1'b0, items};
    endfunction

endpackage

// File: rtl/dsu_decode.sv
module dsu_decode
    import dsu_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] pop_items,
    input  logic [1:0] push_items,
    output dsu_ctl_t   ctl
);
    always_comb begin
        ctl.sel_ret = mode[MODE_RET];
        ctl.need_b  = item_bytes(pop_items, mode[MODE_SHORT]);
        ctl.push_b  = item_bytes(push_items, mode[MODE_SHORT]);
        ctl.pop_b   = mode[MODE_KEEP] ? '0 : ctl.need_b;
    end
endmodule

// File: rtl/dsu_stack.sv
module dsu_stack
    import dsu_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 brk,
    input  logic [CNT_W-1:0]     pop_b,
    input  logic [CNT_W-1:0]     need_b,
    input  logic [CNT_W-1:0]     push_b,
    input  logic [8*MAX_BYTES-1:0] push_data,
    input  logic                 push_tag,
    output logic [8*MAX_BYTES-1:0] top,
    output logic [DW-1:0]        depth,
    output logic                 busy,
    output logic                 fault
);
    dsu_ent_t      ent [DEPTH];
    dsu_ent_t      shf [DEPTH];
    dsu_ent_t      stp [DEPTH];
    logic [DW-1:0] tag_cnt;
    logic [DW-1:0] popped_tags;
    logic          unwinding;
    logic [DW:0]   after;
    logic          under, over, do_op;

    // shifted image for a normal command
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = i + int'(pop_b) - int'(push_b);
            shf[i] = '0;
            if (i < int'(push_b)) begin
                shf[i].val = push_data[8*(i % MAX_BYTES) +: 8];
                shf[i].tag = push_tag && (i == int'(push_b) - 1);
            end else if (src < DEPTH) begin
                shf[i] = ent[src];
            end
        end
    end

    // one-byte pop image for unwinding
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            stp[i] = (i + 1 < DEPTH) ? ent[(i + 1) % DEPTH] : '0;
        end
    end

    always_comb begin
        popped_tags = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (k < int'(pop_b) && ent[k].tag) popped_tags = popped_tags + 1'b1;
        end
    end

    assign after = {1'b0, depth} - (DW+1)'(pop_b) + (DW+1)'(push_b);
    assign under = DW'(need_b) > depth;
    assign over  = after > (DW+1)'(DEPTH);
    assign do_op = en && !brk && !unwinding;
    assign fault = do_op && (under || over);
    assign busy  = unwinding;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            depth     <= '0;
            tag_cnt   <= '0;
            unwinding <= 1'b0;
        end else if (unwinding) begin
            if (ent[0].tag || depth == '0) begin
                unwinding <= 1'b0;
            end else begin
                for (int i = 0; i < DEPTH; i++) ent[i] <= stp[i];
                depth <= depth - 1'b1;
            end
        end else if (en && brk) begin
            unwinding <= (tag_cnt != '0);
        end else if (do_op && !under && !over) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= shf[i];
            depth   <= after[DW-1:0];
            tag_cnt <= tag_cnt - popped_tags
                       + DW'(push_tag && (push_b != '0));
        end
    end

    generate
        for (genvar g = 0; g < MAX_BYTES; g++) begin : g_top
            assign top[8*g +: 8] = ent[g].val;
        end
    endgenerate
endmodule

// File: rtl/dsu.sv
module dsu
    import dsu_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_mode,
    input  logic [1:0]  cmd_pop,
    input  logic [1:0]  cmd_push,
    input  logic        cmd_brk,
    input  logic        cmd_tag,
    input  logic [47:0] cmd_data,
    input  logic [7:0]  io_addr,
    output logic [7:0]  io_rdata,
    output logic [47:0] wst_top,
    output logic [47:0] ret_top,
    output logic [8:0]  wst_depth,
    output logic [8:0]  ret_depth,
    output logic        busy,
    output logic        err
);
    localparam int DW = $clog2(DEPTH + 1);
    localparam int NSTK = 2;

    dsu_ctl_t              ctl;
    logic                  accept;
    logic [8*MAX_BYTES-1:0] tops   [NSTK];
    logic [DW-1:0]         depths [NSTK];
    logic [NSTK-1:0]       s_busy, s_fault;
    logic                  err_q;

    dsu_decode u_dec (
        .mode       (cmd_mode),
        .pop_items  (cmd_pop),
        .push_items (cmd_push),
        .ctl        (ctl)
    );

    assign accept = cmd_valid && (s_busy == '0);

    generate
        for (genvar s = 0; s < NSTK; s++) begin : g_stk
            dsu_stack #(.DEPTH(DEPTH), .DW(DW)) u_stk (
                .clk       (clk),
                .rst       (rst),
                .en        (accept && (ctl.sel_ret == (s == 1))),
                .brk       (cmd_brk),
                .pop_b     (ctl.pop_b),
                .need_b    (ctl.need_b),
                .push_b    (ctl.push_b),
                .push_data (cmd_data),
                .push_tag  (cmd_tag),
                .top       (tops[s]),
                .depth     (depths[s]),
                .busy      (s_busy[s]),
                .fault     (s_fault[s])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q || (s_fault != '0);
    end

    always_comb begin
        case (io_addr)
            8'h02:   io_rdata = 8'(depths[0]);
            8'h03:   io_rdata = 8'(depths[1]);
            default: io_rdata = 8'h00;
        endcase
    end

    assign wst_top   = tops[0];
    assign ret_top   = tops[1];
    assign wst_depth = 9'(depths[0]);
    assign ret_depth = 9'(depths[1]);
    assign busy      = (s_busy != '0);
    assign err       = err_q;
endmodule

// File: rtl/dsu_chk.sv
module dsu_chk #(
    parameter int DEPTH = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_mode,
    input logic       cmd_brk,
    input logic       busy,
    input logic       err,
    input logic [8:0] wst_depth,
    input logic [8:0] ret_depth
);
    logic acc;
    assign acc = cmd_valid && !busy;

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R4
    keep_no_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !cmd_brk && cmd_mode[2] && !cmd_mode[1])
        |=> wst_depth >= $past(wst_depth));

    // R2
    other_stack_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !cmd_brk && !cmd_mode[1]) |=> $stable(ret_depth));

    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (wst_depth <= 9'(DEPTH)) && (ret_depth <= 9'(DEPTH)));

    // R9
    unwind_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (wst_depth <= $past(wst_depth)) && (ret_depth <= $past(ret_depth)));
endmodule

bind dsu dsu_chk #(.DEPTH(DEPTH)) u_dsu_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_mode  (cmd_mode),
    .cmd_brk   (cmd_brk),
    .busy      (busy),
    .err       (err),
    .wst_depth (wst_depth),
    .ret_depth (ret_depth)
);

// File: tb/test_dsu.sv
module test_dsu;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_brk, cmd_tag;
    logic [2:0]  cmd_mode;
    logic [1:0]  cmd_pop, cmd_push;
    logic [47:0] cmd_data;
    logic [7:0]  io_addr, io_rdata;
    logic [47:0] wst_top, ret_top;
    logic [8:0]  wst_depth, ret_depth;
    logic        busy, err;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dsu i_dsu (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_pop(cmd_pop), .cmd_push(cmd_push), .cmd_brk(cmd_brk),
        .cmd_tag(cmd_tag), .cmd_data(cmd_data), .io_addr(io_addr),
        .io_rdata(io_rdata), .wst_top(wst_top), .ret_top(ret_top),
        .wst_depth(wst_depth), .ret_depth(ret_depth), .busy(busy), .err(err)
    );

    // {opcode 8, pop 4, push 4, data 16, exp wdepth 8, exp rdepth 8, exp wtop16, exp rtop16}
    localparam logic [79:0] VEC [9] = '{
        {8'h00, 4'd0, 4'd1, 16'h0011, 8'd1, 8'd0, 16'h0011, 16'h0000},
        {8'h00, 4'd0, 4'd2, 16'h3322, 8'd3, 8'd0, 16'h3322, 16'h0000},
        {8'h20, 4'd0, 4'd1, 16'hBBAA, 8'd5, 8'd0, 16'hBBAA, 16'h0000},
        {8'h00, 4'd1, 4'd0, 16'h0000, 8'd4, 8'd0, 16'h22BB, 16'h0000},
        {8'h80, 4'd2, 4'd1, 16'h0044, 8'd5, 8'd0, 16'hBB44, 16'h0000},
        {8'h40, 4'd0, 4'd2, 16'h5566, 8'd5, 8'd2, 16'hBB44, 16'h5566},
        {8'h60, 4'd1, 4'd0, 16'h0000, 8'd5, 8'd0, 16'hBB44, 16'h0000},
        {8'h20, 4'd1, 4'd1, 16'h7788, 8'd5, 8'd0, 16'h7788, 16'h0000},
        {8'hA0, 4'd2, 4'd1, 16'h99AA, 8'd7, 8'd0, 16'h99AA, 16'h0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cmd_valid = 1'b0; cmd_brk = 1'b0; cmd_tag = 1'b0;
        cmd_mode = '0; cmd_pop = '0; cmd_push = '0; cmd_data = '0; io_addr = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic issue(input logic [7:0] op, input int pop, input int push,
                         input logic [47:0] data, input logic brk, input logic tag);
        cmd_mode = op[7:5]; cmd_pop = 2'(pop); cmd_push = 2'(push);
        cmd_data = data; cmd_brk = brk; cmd_tag = tag; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_brk = 1'b0; cmd_tag = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 wdepth", 64'(wst_depth), 0);
        check("R1 rdepth", 64'(ret_depth), 0);
        check("R1 err/busy", {62'd0, err, busy}, 0);
        check("R1 tops", 64'(wst_top | ret_top), 0);

        // table: R2 selection/order, R3 short, R4 keep
        for (int v = 0; v < 9; v++) begin
            logic [79:0] e;
            e = VEC[v];
            issue(e[79:72], int'(e[71:68]), int'(e[67:64]), {32'd0, e[63:48]}, 1'b0, 1'b0);
            check("R2/R3/R4 wdepth", 64'(wst_depth), 64'(e[47:40]));
            check("R2/R3/R4 rdepth", 64'(ret_depth), 64'(e[39:32]));
            check("R2/R3/R4 wtop", 64'(wst_top[15:0]), 64'(e[31:16]));
            check("R2 rtop", 64'(ret_top[15:0]), 64'(e[15:0]));
        end
        check("R12 six bytes", 64'(wst_top), 64'(48'h3322_7788_99AA));
        check("R7 no err yet", 64'(err), 0);

        // R11 I/O reads
        io_addr = 8'h02; #1 check("R11 port 02", 64'(io_rdata), 7);
        io_addr = 8'h03; #1 check("R11 port 03", 64'(io_rdata), 0);
        io_addr = 8'h05; #1 check("R11 other", 64'(io_rdata), 0);
        @(negedge clk);

        // R5 underflow on empty return stack, then R7 stickiness
        issue(8'h40, 1, 0, 48'd0, 1'b0, 1'b0);
        check("R5 err", 64'(err), 1);
        check("R5 rdepth unchanged", 64'(ret_depth), 0);
        check("R5 wdepth unchanged", 64'(wst_depth), 7);
        issue(8'h40, 0, 1, 48'h5A, 1'b0, 1'b0);
        check("R7 err held", 64'(err), 1);
        check("R7 later cmd runs", 64'(ret_depth), 1);
        check("R7 later cmd data", 64'(ret_top[7:0]), 8'h5A);

        // R6 overflow
        do_reset();
        check("R7 cleared by reset", 64'(err), 0);
        for (int k = 0; k < 42; k++) issue(8'h20, 0, 3, 48'h0102_0304_0506, 1'b0, 1'b0);
        issue(8'h20, 0, 2, 48'hCCDD, 1'b0, 1'b0);
        check("R6 full depth", 64'(wst_depth), 256);
        check("R6 no err at full", 64'(err), 0);
        io_addr = 8'h02; #1 check("R11 low byte at 256", 64'(io_rdata), 0);
        @(negedge clk);
        issue(8'h80, 1, 1, 48'hEE, 1'b0, 1'b0);
        check("R6 keep overflow err", 64'(err), 1);
        check("R6 depth unchanged", 64'(wst_depth), 256);
        check("R6 top unchanged", 64'(wst_top[15:0]), 16'hCCDD);

        // R9 unwind with commands ignored while busy
        do_reset();
        issue(8'h00, 0, 1, 48'h01, 1'b0, 1'b0);
        issue(8'h00, 0, 1, 48'h02, 1'b0, 1'b1);
        issue(8'h00, 0, 3, 48'h05_04_03, 1'b0, 1'b0);
        check("R9 setup depth", 64'(wst_depth), 5);
        issue(8'h00, 0, 0, 48'd0, 1'b1, 1'b0);
        check("R9 busy", 64'(busy), 1);
        cmd_mode = 3'b000; cmd_pop = 2'd0; cmd_push = 2'd1; cmd_data = 48'hEE;
        cmd_valid = 1'b1;
        cyc = 0;
        while (busy && cyc < 20) begin @(negedge clk); cyc++; end
        cmd_valid = 1'b0;
        check("R9 busy cycles", 64'(cyc), 4);
        check("R9 depth at mark", 64'(wst_depth), 2);
        check("R9 mark on top", 64'(wst_top[15:0]), 16'h0102);

        // R8 only deepest pushed byte marked
        issue(8'h00, 0, 2, 48'hB2A1, 1'b0, 1'b1);
        issue(8'h00, 0, 0, 48'd0, 1'b1, 1'b0);
        cyc = 0;
        while (busy && cyc < 20) begin @(negedge clk); cyc++; end
        check("R8 stops at deepest pushed", 64'(wst_depth), 3);
        check("R8 top", 64'(wst_top[7:0]), 8'hB2);

        // R10 break with no mark
        issue(8'h40, 0, 2, 48'h3344, 1'b0, 1'b0);
        issue(8'h40, 0, 0, 48'd0, 1'b1, 1'b0);
        check("R10 no busy", 64'(busy), 0);
        @(negedge clk);
        check("R10 rdepth kept", 64'(ret_depth), 2);
        check("R10 rtop kept", 64'(ret_top[15:0]), 16'h3344);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule